// File: doc/BRIEF.md
# Differential Third-Order 31-Level Noise Shaper with Element Rotation

This block turns 24-bit two's-complement audio samples into a pair of coarse, noise-shaped level streams that feed two unit-element current DACs. An input sample is captured in a holding register. It is then reused on every shaper strobe until a new sample replaces it. This zero-order hold raises the data rate from the input rate to the shaper rate by the whole ratio n between the two strobes. The total delay from capture to first use is below one input period.

Two identical shapers run side by side. One works on the captured sample and the other on its negation, which gives a differential pair. Each shaper is a third-order error-feedback modulator. Its quantiser rounds to one of 31 levels, from -15 to +15, and the quantisation error is fed back through (1 - z^-1)^3. Each level q is then expanded into a 30-bit word with exactly q+15 active elements. The active elements form a circular run that starts at a rotating pointer. After each strobe the pointer moves on by the number of elements just used, so mismatch between the elements is spread over time.

Top module: `dsm31_pair`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `out_strobe` is 0, both level outputs are 0 and both element words are all zero. Reset also clears the held sample, the error history and both rotation pointers.
- R2: `out_strobe` is high in exactly the cycle after each cycle in which `ns_tick` is high, and it is low at all other times.
- R3: A sample presented with `smp_load` high is used by every `ns_tick` that comes strictly after that cycle, until the next load. A tick in the same cycle as a load still uses the previous sample.
- R4: On each tick, the direct channel forms x = sample >>> 1, with the shift arithmetic and rounding toward minus infinity. It then forms v = x - (3e1 - 3e2 + e3), where e1, e2 and e3 are the last three errors. The level is q = floor((v + 2^18) / 2^19), clamped to [-15, +15], and the new error is e = q*2^19 - v.
- R5: The inverted channel applies the same arithmetic to the negated sample, with its own error history, and its level appears on `lvl_neg`.
- R6: Whenever `out_strobe` is high, each element word has exactly level+15 bits set. The levels are 5-bit two's complement.
- R7: Each channel has a pointer p in 0..29 that is 0 after reset. With k = level+15, bit i of the element word is set exactly when (i - p) mod 30 < k. The pointer then becomes (p + k) mod 30.
- R8: For any 24-bit input, including both full-scale extremes, the unclamped level stays within +/-15 and the error stays within +/-2^18.
- R9: For a constant input X, the sum of N consecutive direct-channel levels is within 3 of N*X/2^20, and the inverted-channel sum is within 3 of -N*X/2^20.
- R10: Cycles without a tick change neither the outputs nor the loop state. The next tick continues the sequence as if those idle cycles had not happened.
- R11: A reset in the middle of a run restarts both the error history and the pointers, so the same stimulus reproduces the same outputs as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shaper clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_load | input | 1 | Captures `smp_data` into the hold register |
| smp_data | input | 24 | Input sample, two's complement |
| ns_tick | input | 1 | Shaper strobe: one loop update per high cycle |
| out_strobe | output | 1 | Marks new levels and element words |
| lvl_pos | output | 5 | Level of the direct channel, -15..+15 |
| lvl_neg | output | 5 | Level of the inverted channel, -15..+15 |
| elem_pos | output | 30 | Element-select word of the direct channel |
| elem_neg | output | 30 | Element-select word of the inverted channel |

## Verification
A zero input keeps the loop at level 0. It therefore isolates the rotator, which must alternate two halves of the element array. A constant mid-scale input shows, through the level sums, that the loop tracks the DC value within the error bound, independently of any bit-exact model. Alternating full-scale extremes, held for several strobes each, drive the quantiser to its overload edge and test the hold over repeated ticks. Pseudo-random samples with varying hold ratios and idle gaps, a load that lands on a tick, and a replay after a mid-run reset separate hold timing, error-history mistakes and rounding mistakes from one another.

// File: rtl/dsm31_pkg.sv
package dsm31_pkg;

  typedef enum logic {PH_DIRECT = 1'b0, PH_INVERT = 1'b1} phase_e;

  // circular add for a pointer kept below m (b never exceeds m)
  function automatic int wrap_sum(input int a, input int b, input int m);
    int s;
    s = a + b;
    return (s >= m) ? s - m : s;
  endfunction

endpackage

// File: rtl/dsm31_hold.sv
module dsm31_hold #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end

endmodule

// File: rtl/dsm31_loop.sv
module dsm31_loop #(
  parameter int DATA_W   = 24,
  parameter int HALF_LVL = 15,
  parameter dsm31_pkg::phase_e PHASE = dsm31_pkg::PH_DIRECT,
  localparam int LVL_W   = $clog2(HALF_LVL + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [DATA_W-1:0]       sample,
  output logic signed [LVL_W-1:0] q_now,
  output logic signed [LVL_W-1:0] lvl_q
);

  localparam int ACC_W = DATA_W + 4;
  localparam int SH    = DATA_W - 1 - $clog2(HALF_LVL + 1);
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (SH - 1);
  localparam logic signed [ACC_W-1:0] QMAX = ACC_W'(HALF_LVL);

  logic signed [ACC_W-1:0] e1_q, e2_q, e3_q;
  logic signed [ACC_W-1:0] x_in, x_sc, fb, v, q_raw, q_full, e_new;

  function automatic logic signed [ACC_W-1:0] fb_calc(
    input logic signed [ACC_W-1:0] a, input logic signed [ACC_W-1:0] b,
    input logic signed [ACC_W-1:0] c);
    return ((a <<< 1) + a) - ((b <<< 1) + b) + c;
  endfunction

  function automatic logic signed [LVL_W-1:0] clamp_lvl(
    input logic signed [ACC_W-1:0] r);
    logic signed [ACC_W-1:0] t;
    t = r;
    if (t > QMAX)       t = QMAX;
    else if (t < -QMAX) t = -QMAX;
    return t[LVL_W-1:0];
  endfunction

  generate
    if (PHASE == dsm31_pkg::PH_INVERT) begin : g_inv
      assign x_in = -ACC_W'($signed(sample));
    end else begin : g_dir
      assign x_in = ACC_W'($signed(sample));
    end
  endgenerate

  always_comb begin
    x_sc   = x_in >>> 1;
    fb     = fb_calc(e1_q, e2_q, e3_q);
    v      = x_sc - fb;
    q_raw  = (v + RND) >>> SH;
    q_now  = clamp_lvl(q_raw);
    q_full = ACC_W'(q_now);
    e_new  = (q_full <<< SH) - v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1_q  <= '0;
      e2_q  <= '0;
      e3_q  <= '0;
      lvl_q <= '0;
    end else if (tick) begin
      e1_q  <= e_new;
      e2_q  <= e1_q;
      e3_q  <= e2_q;
      lvl_q <= q_now;
    end
  end

  // input scaling keeps the quantiser out of clipping for every sample
  p_no_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (q_raw <= QMAX && q_raw >= -QMAX));

  // rounding error never exceeds half a step
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (e_new <= RND && e_new >= -RND));

  // idle cycles leave the loop untouched
  p_hold_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(lvl_q) && $stable(e1_q) && $stable(e3_q)));

endmodule

// File: rtl/dsm31_dem.sv
module dsm31_dem #(
  parameter int HALF_LVL = 15,
  localparam int ELEMS   = 2 * HALF_LVL,
  localparam int LVL_W   = $clog2(HALF_LVL + 1) + 1,
  localparam int PTR_W   = $clog2(ELEMS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic signed [LVL_W-1:0] lvl,
  output logic [ELEMS-1:0]        elem_q
);

  logic [PTR_W-1:0] ptr_q, ptr_next;
  logic [ELEMS-1:0] mask;
  int               cnt;

  assign cnt      = int'(lvl) + HALF_LVL;
  assign ptr_next = PTR_W'(dsm31_pkg::wrap_sum(int'(ptr_q), cnt, ELEMS));

  for (genvar i = 0; i < ELEMS; i++) begin : g_el
    always_comb begin
      int d;
      d = i - int'(ptr_q);
      if (d < 0) d = d + ELEMS;
      mask[i] = (d < cnt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      elem_q <= '0;
    end else if (tick) begin
      ptr_q  <= ptr_next;
      elem_q <= mask;
    end
  end

  p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < ELEMS);

  // the run of active elements begins at the old pointer
  p_run_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != 0) |=> elem_q[$past(ptr_q)]);

endmodule

// File: rtl/dsm31_pair.sv
module dsm31_pair #(
  parameter int DATA_W   = 24,
  parameter int HALF_LVL = 15,
  localparam int LVL_W   = $clog2(HALF_LVL + 1) + 1,
  localparam int ELEMS   = 2 * HALF_LVL
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_load,
  input  logic [DATA_W-1:0]       smp_data,
  input  logic                    ns_tick,
  output logic                    out_strobe,
  output logic signed [LVL_W-1:0] lvl_pos,
  output logic signed [LVL_W-1:0] lvl_neg,
  output logic [ELEMS-1:0]        elem_pos,
  output logic [ELEMS-1:0]        elem_neg
);

  logic [DATA_W-1:0]       held;
  logic signed [LVL_W-1:0] q_now [2];
  logic signed [LVL_W-1:0] lvl_arr [2];
  logic [ELEMS-1:0]        elem_arr [2];

  dsm31_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(smp_load), .din(smp_data), .dout(held)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    dsm31_loop #(
      .DATA_W(DATA_W), .HALF_LVL(HALF_LVL),
      .PHASE(c == 0 ? dsm31_pkg::PH_DIRECT : dsm31_pkg::PH_INVERT)
    ) u_loop (
      .clk(clk), .rst_n(rst_n), .tick(ns_tick), .sample(held),
      .q_now(q_now[c]), .lvl_q(lvl_arr[c])
    );
    dsm31_dem #(.HALF_LVL(HALF_LVL)) u_dem (
      .clk(clk), .rst_n(rst_n), .tick(ns_tick), .lvl(q_now[c]),
      .elem_q(elem_arr[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_strobe <= 1'b0;
    else        out_strobe <= ns_tick;
  end

  assign lvl_pos  = lvl_arr[0];
  assign lvl_neg  = lvl_arr[1];
  assign elem_pos = elem_arr[0];
  assign elem_neg = elem_arr[1];

  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ns_tick |=> out_strobe);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ns_tick |=> !out_strobe);

  // element counts follow the levels in both channels
  p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> ($countones(elem_pos) == int'(lvl_pos) + HALF_LVL &&
                    $countones(elem_neg) == int'(lvl_neg) + HALF_LVL));

endmodule

// File: tb/dsm31_pair_bench.sv
module dsm31_pair_bench;

  localparam int DW = 24;
  localparam int HL = 15;
  localparam int NE = 2 * HL;
  localparam longint STEP = 64'sd1 <<< (DW - 5);

  logic clk = 1'b0, rst_n = 1'b0, smp_load = 1'b0, ns_tick = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic out_strobe;
  logic signed [4:0] lvl_pos, lvl_neg;
  logic [NE-1:0] elem_pos, elem_neg;

  dsm31_pair u_dsm31_pair (
    .clk(clk), .rst_n(rst_n), .smp_load(smp_load), .smp_data(smp_data),
    .ns_tick(ns_tick), .out_strobe(out_strobe), .lvl_pos(lvl_pos),
    .lvl_neg(lvl_neg), .elem_pos(elem_pos), .elem_neg(elem_neg)
  );

  always #5 clk = ~clk;

  typedef struct {int lv[2]; logic [NE-1:0] el[2];} exp_t;
  exp_t exp_q[$];

  int total = 0, bad = 0;
  string ctx = "R1";
  logic [DW-1:0] m_held = '0;
  longint m_e1[2], m_e2[2], m_e3[2];
  int m_ptr[2];
  bit have_last = 0, acc_on = 0;
  int last_lp, last_ln, sum_p, sum_n, acc_n;

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_e1[c] = 0; m_e2[c] = 0; m_e3[c] = 0; m_ptr[c] = 0;
    end
    m_held = '0;
  endtask

  // expected levels and element words for one strobe, restated from R4..R7
  function automatic exp_t model_step();
    exp_t r;
    for (int c = 0; c < 2; c++) begin
      longint x, v, q, e;
      int k;
      x = longint'($signed(m_held));
      if (c == 1) x = -x;
      v = (x >>> 1) - (3 * m_e1[c] - 3 * m_e2[c] + m_e3[c]);
      q = (v + STEP / 2) >>> (DW - 5);
      if (q > HL) q = HL;
      if (q < -HL) q = -HL;
      e = q * STEP - v;
      m_e3[c] = m_e2[c]; m_e2[c] = m_e1[c]; m_e1[c] = e;
      k = int'(q) + HL;
      for (int i = 0; i < NE; i++)
        r.el[c][i] = (((i - m_ptr[c] + NE) % NE) < k);
      m_ptr[c] = (m_ptr[c] + k) % NE;
      r.lv[c] = int'(q);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input longint got, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] got=%0d exp=%0d", what, ctx, got, expv);
    end
  endtask

  task automatic do_load(input logic [DW-1:0] s);
    @(posedge clk); #1;
    smp_load = 1'b1; smp_data = s; m_held = s;
    @(posedge clk); #1;
    smp_load = 1'b0;
  endtask

  task automatic do_tick(input int gap);
    @(posedge clk); #1;
    ns_tick = 1'b1;
    exp_q.push_back(model_step());
    @(posedge clk); #1;
    ns_tick = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  task automatic load_with_tick(input logic [DW-1:0] s);
    @(posedge clk); #1;
    smp_load = 1'b1; smp_data = s; ns_tick = 1'b1;
    exp_q.push_back(model_step());
    m_held = s;
    @(posedge clk); #1;
    smp_load = 1'b0; ns_tick = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    model_reset();
    have_last = 0;
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_strobe) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 strobe without tick", 1, 0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          check(int'(lvl_pos) == x.lv[0], "R4 lvl_pos", lvl_pos, x.lv[0]);
          check(int'(lvl_neg) == x.lv[1], "R5 lvl_neg", lvl_neg, x.lv[1]);
          check(elem_pos == x.el[0], "R7 elem_pos", elem_pos, x.el[0]);
          check(elem_neg == x.el[1], "R7 elem_neg", elem_neg, x.el[1]);
        end
        check($countones(elem_pos) == int'(lvl_pos) + HL, "R6 count pos",
              $countones(elem_pos), int'(lvl_pos) + HL);
        check(lvl_pos <= HL && lvl_pos >= -HL, "R8 range pos", lvl_pos, HL);
        last_lp = lvl_pos; last_ln = lvl_neg; have_last = 1;
        if (acc_on) begin
          sum_p += lvl_pos; sum_n += lvl_neg; acc_n++;
        end
      end else if (have_last) begin
        check(int'(lvl_pos) == last_lp && int'(lvl_neg) == last_ln,
              "R10 idle hold", lvl_pos, last_lp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rnd;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    ctx = "R1";
    check(out_strobe == 0, "R1 reset strobe", out_strobe, 0);
    check(lvl_pos == 0 && lvl_neg == 0, "R1 reset levels", lvl_pos, 0);
    check(elem_pos == '0 && elem_neg == '0, "R1 reset elements", elem_pos, 0);

    ctx = "R7 zero input";
    for (int t = 0; t < 20; t++) do_tick(t % 3);

    ctx = "R9 dc";
    do_load(24'h300000);
    repeat (2) @(posedge clk);
    sum_p = 0; sum_n = 0; acc_n = 0; acc_on = 1;
    for (int t = 0; t < 200; t++) do_tick(0);
    repeat (3) @(posedge clk);
    acc_on = 0;
    check(acc_n == 200, "R9 sample count", acc_n, 200);
    check(sum_p >= 597 && sum_p <= 603, "R9 dc sum pos", sum_p, 600);
    check(sum_n >= -603 && sum_n <= -597, "R9 dc sum neg", sum_n, -600);

    ctx = "R8 full scale";
    for (int t = 0; t < 12; t++) begin
      do_load(t[0] ? 24'h800000 : 24'h7FFFFF);
      for (int j = 0; j < 3; j++) do_tick(0);
    end

    ctx = "R3 R10 random";
    rnd = 24'hACE123;
    for (int t = 0; t < 60; t++) begin
      rnd = {rnd[22:0], rnd[23] ^ rnd[22] ^ rnd[21] ^ rnd[16]};
      do_load(rnd);
      for (int j = 0; j <= (t % 4); j++) do_tick(t % 5);
    end

    ctx = "R3 load on tick";
    load_with_tick(24'h123456);
    do_tick(1);
    load_with_tick(24'hF00001);
    do_tick(0);
    do_tick(2);

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R2 pending strobes", exp_q.size(), 0);

    ctx = "R11 replay";
    for (int pass = 0; pass < 2; pass++) begin
      do_reset();
      @(negedge clk);
      check(out_strobe == 0 && elem_pos == '0, "R11 after reset", elem_pos, 0);
      do_load(24'h0A5F31);
      for (int t = 0; t < 15; t++) do_tick(t % 2);
      do_load(24'hF3C001);
      for (int t = 0; t < 15; t++) do_tick(0);
    end

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R2 final queue", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule